// File: doc/BRIEF.md
# Partitioned Paged Packet Buffer

This block holds 8 kB of on-chip storage shared between a processor byte port and a packet-engine word port. The storage is cut into 32 pages of 64 four-byte words. A 5-bit split register sets how many of the lowest pages form the receive region. The rest, up to page 31, form the transmit region. Packets may run across several consecutive pages inside their region. Word 0 of every page is set aside for that page's status.

The processor reaches the storage through a 24-bit byte address. A 2-bit window mode picks where the 8 kB appears in that address space. The packet engine addresses a page and a word directly. It gets the whole word, plus flags that tell whether the page is a receive page and whether the word is the status word. Any write that really changes the split raises a one-cycle flush pulse, so that the neighbouring receive logic can discard what it holds.

Top module: `pkt_page_buffer`

## Requirements
- R1: The split register resets to 0, so every page reads as a transmit page (`engIsRx` low for every page) and `flushPulse` is low.
- R2: With split value n, page p is a receive page exactly when p < n. Value 16 gives receive pages 0..15 and transmit pages 16..31. Value 31 leaves page 31 as the only transmit page.
- R3: A `cfgWe` cycle whose `cfgData` differs from the current split loads the new value, which is visible on `rxPages` the next cycle. `flushPulse` is high for exactly that one cycle.
- R4: A `cfgWe` cycle that carries the current split value leaves `flushPulse` low.
- R5: The processor window is selected by `winMode`. Mode 0 maps 0x00E000..0x00FFFF, mode 1 maps 0x000000..0x001FFF, mode 2 maps 0xFFE000..0xFFFFFF, and mode 3 maps nothing. `cpuHit` is high during a request whose address falls in the active window.
- R6: Inside the window, address bits [12:8] select the page, bits [7:2] select the word and bits [1:0] select the byte. Byte b of a word sits in word bits [8b+7:8b]. For example, offset 0x010B is page 1, word 2, byte 3, which is word bits [31:24].
- R7: A processor read that is accepted returns its byte on `cpuRdata`, with `cpuRvalid` high, one cycle later. A processor write updates only the addressed byte.
- R8: A processor access that misses the window, or any access with mode 3, leaves the storage unchanged. A read that misses still raises `cpuRvalid` one cycle later, with `cpuRdata` equal to 0x00.
- R9: An engine write stores all 32 bits at the addressed page and word. An engine read returns the word on `engRdata`, with `engRvalid` high, one cycle later.
- R10: When the engine and an in-window processor access request in the same cycle, the engine is served. `cpuWait` is high that cycle, and the processor access completes in the first cycle it is presented without an engine request.
- R11: `engIsStatus` is high exactly when `engWord` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgWe | input | 1 | Write strobe for the split register |
| cfgData | input | 5 | New receive page count |
| rxPages | output | 5 | Current receive page count |
| flushPulse | output | 1 | One-cycle receive flush request |
| winMode | input | 2 | Processor address window select |
| cpuReq | input | 1 | Processor access request |
| cpuWe | input | 1 | Processor write (1) or read (0) |
| cpuAddr | input | 24 | Processor byte address |
| cpuWdata | input | 8 | Processor write byte |
| cpuHit | output | 1 | Request address falls in the window |
| cpuWait | output | 1 | Processor access held off this cycle |
| cpuRvalid | output | 1 | Processor read result valid |
| cpuRdata | output | 8 | Processor read byte |
| engReq | input | 1 | Engine access request |
| engWe | input | 1 | Engine write (1) or read (0) |
| engPage | input | 5 | Engine page index |
| engWord | input | 6 | Engine word index within the page |
| engWdata | input | 32 | Engine write word |
| engIsRx | output | 1 | Addressed page is a receive page |
| engIsStatus | output | 1 | Addressed word is the page status word |
| engRvalid | output | 1 | Engine read result valid |
| engRdata | output | 32 | Engine read word |

## Verification
The bench builds the block with its default parameters: 32 pages of 64 words and the three standard window bases. At that size the extreme split values 0, 16 and 31 and the last page are cheap to reach. The same byte can be reached through all three live windows, so the window decode is checked against one shared storage image. A scoreboard model of the storage is checked against both ports. This shows that bytes written by the processor appear in the correct lane of engine words, and the other way round.

// File: rtl/pkbuf_pkg.sv
package pkbuf_pkg;
  localparam int PAGE_W = 5;
  localparam int WORD_W = 6;
  localparam int LANE_W = 2;
  localparam int LANES  = 1 << LANE_W;
  localparam int DATA_W = 8 * LANES;
  localparam int IDX_W  = PAGE_W + WORD_W;

  typedef struct packed {
    logic              memEn;
    logic              memWe;
    logic [IDX_W-1:0]  memIdx;
    logic [LANES-1:0]  laneEn;
    logic [DATA_W-1:0] wdata;
    logic              cpuRd;
    logic [LANE_W-1:0] cpuLane;
  } memStrobe_t;
endpackage

// File: rtl/pkbuf_ctrl.sv
module pkbuf_ctrl
  import pkbuf_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE_M0 = 24'h00E000,
  parameter logic [ADDR_W-1:0] BASE_M1 = 24'h000000,
  parameter logic [ADDR_W-1:0] BASE_M2 = 24'hFFE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [PAGE_W-1:0] cfgData,
  output logic [PAGE_W-1:0] rxPages,
  output logic              flushPulse,
  input  logic [1:0]        winMode,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic              cpuHit,
  output logic              cpuWait,
  output logic              cpuRvalid,
  input  logic              engReq,
  input  logic              engWe,
  input  logic [PAGE_W-1:0] engPage,
  input  logic [WORD_W-1:0] engWord,
  input  logic [DATA_W-1:0] engWdata,
  output logic              engIsRx,
  output logic              engIsStatus,
  output logic              engRvalid,
  output memStrobe_t        strobe
);
  localparam int OFF_W = IDX_W + LANE_W;
  localparam int TOP_W = ADDR_W - OFF_W;

  logic [TOP_W-1:0] winTop;
  logic             winLive;
  logic             grantCpu;

  always_comb begin
    winLive = 1'b1;
    unique case (winMode)
      2'd0:    winTop = BASE_M0[ADDR_W-1:OFF_W];
      2'd1:    winTop = BASE_M1[ADDR_W-1:OFF_W];
      2'd2:    winTop = BASE_M2[ADDR_W-1:OFF_W];
      default: begin winTop = '0; winLive = 1'b0; end
    endcase
  end

  assign cpuHit   = cpuReq && winLive && (cpuAddr[ADDR_W-1:OFF_W] == winTop);
  assign cpuWait  = cpuHit && engReq;
  assign grantCpu = cpuHit && !engReq;

  assign engIsRx     = engPage < rxPages;
  assign engIsStatus = engWord == '0;

  always_comb begin
    strobe = '0;
    if (engReq) begin
      strobe.memEn  = 1'b1;
      strobe.memWe  = engWe;
      strobe.memIdx = {engPage, engWord};
      strobe.laneEn = '1;
      strobe.wdata  = engWdata;
    end else if (grantCpu) begin
      strobe.memEn   = 1'b1;
      strobe.memWe   = cpuWe;
      strobe.memIdx  = cpuAddr[OFF_W-1:LANE_W];
      strobe.laneEn  = LANES'(1) << cpuAddr[LANE_W-1:0];
      strobe.wdata   = {LANES{cpuWdata}};
      strobe.cpuRd   = !cpuWe;
      strobe.cpuLane = cpuAddr[LANE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPages    <= '0;
      flushPulse <= 1'b0;
      cpuRvalid  <= 1'b0;
      engRvalid  <= 1'b0;
    end else begin
      flushPulse <= cfgWe && (cfgData != rxPages);
      if (cfgWe) rxPages <= cfgData;
      cpuRvalid <= cpuReq && !cpuWe && !cpuWait;
      engRvalid <= engReq && !engWe;
    end
  end

  // R3
  flush_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> rxPages != $past(rxPages));
  // R3
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |=> !flushPulse);
  // R4
  same_value_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgData == rxPages) |=> !flushPulse);
  // R10
  stall_no_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWait && !cpuWe) |=> !cpuRvalid);
  // R9
  eng_read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && !engWe) |=> engRvalid);
endmodule

// File: rtl/pkbuf_datapath.sv
module pkbuf_datapath
  import pkbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  output logic [DATA_W-1:0] engRdata,
  output logic [7:0]        cpuRdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] readWord;
  logic [LANE_W-1:0] readLane;
  logic              readForCpu;

  always_ff @(posedge clk) begin
    if (strobe.memEn && strobe.memWe) begin
      for (int i = 0; i < LANES; i++) begin
        if (strobe.laneEn[i]) mem[strobe.memIdx][8*i +: 8] <= strobe.wdata[8*i +: 8];
      end
    end
    if (strobe.memEn && !strobe.memWe) readWord <= mem[strobe.memIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readLane   <= '0;
      readForCpu <= 1'b0;
    end else begin
      readLane   <= strobe.cpuLane;
      readForCpu <= strobe.cpuRd;
    end
  end

  assign engRdata = readWord;
  assign cpuRdata = readForCpu ? readWord[8*readLane +: 8] : 8'h00;

  // R8
  idle_byte_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cpuRd |=> cpuRdata == 8'h00);
endmodule

// File: rtl/pkt_page_buffer.sv
module pkt_page_buffer
  import pkbuf_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE_M0 = 24'h00E000,
  parameter logic [ADDR_W-1:0] BASE_M1 = 24'h000000,
  parameter logic [ADDR_W-1:0] BASE_M2 = 24'hFFE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [PAGE_W-1:0] cfgData,
  output logic [PAGE_W-1:0] rxPages,
  output logic              flushPulse,
  input  logic [1:0]        winMode,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic              cpuHit,
  output logic              cpuWait,
  output logic              cpuRvalid,
  output logic [7:0]        cpuRdata,
  input  logic              engReq,
  input  logic              engWe,
  input  logic [PAGE_W-1:0] engPage,
  input  logic [WORD_W-1:0] engWord,
  input  logic [DATA_W-1:0] engWdata,
  output logic              engIsRx,
  output logic              engIsStatus,
  output logic              engRvalid,
  output logic [DATA_W-1:0] engRdata
);
  memStrobe_t strobe;

  pkbuf_ctrl #(
    .ADDR_W(ADDR_W), .BASE_M0(BASE_M0), .BASE_M1(BASE_M1), .BASE_M2(BASE_M2)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgData(cfgData), .rxPages(rxPages), .flushPulse(flushPulse),
    .winMode(winMode), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuHit(cpuHit), .cpuWait(cpuWait), .cpuRvalid(cpuRvalid),
    .engReq(engReq), .engWe(engWe), .engPage(engPage), .engWord(engWord),
    .engWdata(engWdata), .engIsRx(engIsRx), .engIsStatus(engIsStatus),
    .engRvalid(engRvalid), .strobe(strobe)
  );

  pkbuf_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .engRdata(engRdata), .cpuRdata(cpuRdata)
  );

  // R8
  miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && !cpuHit) |=> (cpuRvalid && cpuRdata == 8'h00));
  // R5
  mode3_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winMode == 2'd3) |-> !cpuHit);
endmodule

// File: tb/sim_pkt_page_buffer.sv
module sim_pkt_page_buffer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic cfgWe = 0; logic [4:0] cfgData = 0; logic [4:0] rxPages; logic flushPulse;
  logic [1:0] winMode = 2'd1;
  logic cpuReq = 0, cpuWe = 0; logic [23:0] cpuAddr = 0; logic [7:0] cpuWdata = 0;
  logic cpuHit, cpuWait, cpuRvalid; logic [7:0] cpuRdata;
  logic engReq = 0, engWe = 0; logic [4:0] engPage = 0; logic [5:0] engWord = 0;
  logic [31:0] engWdata = 0; logic engIsRx, engIsStatus, engRvalid; logic [31:0] engRdata;

  pkt_page_buffer u0 (.*);

  int checks = 0, errors = 0;
  logic [7:0]  model [8192];
  logic [7:0]  cpuQ [$];
  logic [31:0] engQ [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected results as the design presents them
  always @(negedge clk) if (rstN) begin
    if (cpuRvalid) begin
      if (cpuQ.size() == 0) check("R7 unexpected cpu result", 32'(cpuRdata), 32'hx);
      else check("R7/R8 cpu read byte", 32'(cpuRdata), 32'(cpuQ.pop_front()));
    end
    if (engRvalid) begin
      if (engQ.size() == 0) check("R9 unexpected engine result", engRdata, 32'hx);
      else check("R9 engine read word", engRdata, engQ.pop_front());
    end
  end

  function automatic logic inWin(input logic [1:0] m, input logic [23:0] a);
    case (m)
      2'd0: return a[23:13] == 11'h007;
      2'd1: return a[23:13] == 11'h000;
      2'd2: return a[23:13] == 11'h7FF;
      default: return 1'b0;
    endcase
  endfunction

  task automatic cpuAcc(input logic we, input logic [23:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    #1 check({req, " cpuHit"}, 32'(cpuHit), 32'(inWin(winMode, a)));
    if (we) begin
      if (inWin(winMode, a)) model[a[12:0]] = d;
    end else cpuQ.push_back(inWin(winMode, a) ? model[a[12:0]] : 8'h00);
    @(negedge clk);
    cpuReq = 0; cpuWe = 0;
  endtask

  task automatic engAcc(input logic we, input logic [4:0] p, input logic [5:0] w, input logic [31:0] d);
    logic [12:0] base;
    base = {p, w, 2'b00};
    @(negedge clk);
    engReq = 1; engWe = we; engPage = p; engWord = w; engWdata = d;
    if (we) for (int i = 0; i < 4; i++) model[base + 13'(i)] = d[8*i +: 8];
    else engQ.push_back({model[base+3], model[base+2], model[base+1], model[base]});
    @(negedge clk);
    engReq = 0; engWe = 0;
  endtask

  task automatic setSplit(input logic [4:0] v, input logic expFlush, input string req);
    @(negedge clk);
    cfgWe = 1; cfgData = v;
    @(negedge clk);
    cfgWe = 0;
    check({req, " flush"}, 32'(flushPulse), 32'(expFlush));
    check({req, " rxPages"}, 32'(rxPages), 32'(v));
    @(negedge clk);
    check({req, " flush one cycle"}, 32'(flushPulse), 32'(0));
  endtask

  task automatic pageKind(input logic [4:0] p, input logic expRx, input string req);
    engPage = p;
    #1 check(req, 32'(engIsRx), 32'(expRx));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rxPages", 32'(rxPages), 0);
    check("R1 flush", 32'(flushPulse), 0);
    pageKind(5'd0, 0, "R1 page0 tx");
    pageKind(5'd31, 0, "R1 page31 tx");

    // R2 R3 R4 split
    setSplit(5'd16, 1, "R3 set 16");
    pageKind(5'd15, 1, "R2 page15 rx");
    pageKind(5'd16, 0, "R2 page16 tx");
    setSplit(5'd16, 0, "R4 same value");
    setSplit(5'd31, 1, "R3 set 31");
    pageKind(5'd30, 1, "R2 page30 rx");
    pageKind(5'd31, 0, "R2 page31 tx");

    // R11 status word flag
    engWord = 6'd0; #1 check("R11 word0 status", 32'(engIsStatus), 1);
    engWord = 6'd2; #1 check("R11 word2 not status", 32'(engIsStatus), 0);

    // R6 R7 R9 layout through both ports
    winMode = 2'd1;
    engAcc(1, 5'd1, 6'd2, 32'h11223344);
    cpuAcc(1, 24'h00010B, 8'hA5, "R6 write page1 word2 byte3");
    engAcc(0, 5'd1, 6'd2, 0);               // expects A5223344
    cpuAcc(0, 24'h000108, 8'h00, "R6 lane0");
    cpuAcc(0, 24'h000109, 8'h00, "R6 lane1");
    engAcc(1, 5'd31, 6'd63, 32'hCAFEF00D);
    cpuAcc(0, 24'h001FFF, 8'h00, "R6 last byte");

    // R5 other windows
    winMode = 2'd0;
    cpuAcc(0, 24'h00E10B, 8'h00, "R5 mode0 read");
    cpuAcc(0, 24'h000108, 8'h00, "R5 mode0 miss");
    winMode = 2'd2;
    cpuAcc(0, 24'hFFE10B, 8'h00, "R5 mode2 read");
    cpuAcc(1, 24'hFFFFFC, 8'h5A, "R5 mode2 write");

    // R8 reserved mode and out of window
    winMode = 2'd3;
    cpuAcc(1, 24'h00010B, 8'h33, "R8 mode3 write");
    cpuAcc(0, 24'h00010B, 8'h00, "R8 mode3 read");
    winMode = 2'd1;
    cpuAcc(1, 24'h00210B, 8'h77, "R8 outside write");
    cpuAcc(0, 24'h00010B, 8'h00, "R8 byte unchanged");
    engAcc(0, 5'd31, 6'd63, 0);

    // R10 contention
    @(negedge clk);
    cpuReq = 1; cpuWe = 0; cpuAddr = 24'h00010B;
    engReq = 1; engWe = 0; engPage = 5'd1; engWord = 6'd2;
    engQ.push_back({model[13'h10B], model[13'h10A], model[13'h109], model[13'h108]});
    cpuQ.push_back(model[13'h10B]);
    #1 check("R10 wait while engine served", 32'(cpuWait), 1);
    @(negedge clk);
    engReq = 0;
    #1 check("R10 wait released", 32'(cpuWait), 0);
    @(negedge clk);
    cpuReq = 0;
    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 32'(cpuQ.size() + engQ.size()), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule